// File: doc/BRIEF.md
# Four-to-Two Carry-Save Compressor Row

This block reduces four operand vectors of equal width to two: a sum vector and a carry vector whose weighted total equals the sum of the four operands. It is the workhorse of a multiplier's partial-product reduction tree. A row of these cells turns four partial-product rows into two, and only the final stage needs a carry-propagate adder.

Each bit lane holds one compressor cell. A cell takes four operand bits and one lateral carry from the lane below. It returns a sum bit, a carry bit and a lateral carry for the lane above. The cell is not two chained full adders. It forms the XOR and the XNOR of one operand pair together and steers the rest of the reduction through 2:1 multiplexers, so its deepest path is three XOR-equivalent levels. The lateral carry that a lane emits is a function of its own first three operand bits only, so a carry never travels more than one lane.

The block is purely combinational, with no clock and no handshake. Outputs follow inputs after logic settling. The lateral carry leaving the top lane is brought out as a separate port of weight 2^WIDTH.

Top module: `cmp42_row`

## Requirements
- R1: For every input, sum_o + 2·carry_o + 2^WIDTH·carry_top_o equals op_a + op_b + op_c + op_d, all taken as unsigned values.
- R2: carry_top_o is 1 exactly when at least two of op_a[WIDTH-1], op_b[WIDTH-1] and op_c[WIDTH-1] are 1. It does not depend on op_d or on any lower bit.
- R3: The lowest lane sees a lateral carry-in of 0. With inputs only at bit 0, op_a[0]=1 and op_d[0]=1 give sum_o=0 and carry_o=1.
- R4: Changing one operand bit at position j changes sum_o and carry_o only at positions j and j+1, and changes carry_top_o only when j = WIDTH-1.
- R5: carry_o[i] is the majority of three terms: op_a[i]^op_b[i]^op_c[i], op_d[i], and the lateral carry from lane i-1. That lateral carry is the majority of op_a, op_b and op_c at bit i-1, or 0 for i=0.
- R6: sum_o[i] is the XOR of op_a[i], op_b[i], op_c[i], op_d[i] and the lateral carry into lane i.
- R7: With all operands zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand row |
| op_b | input | WIDTH | Second operand row |
| op_c | input | WIDTH | Third operand row |
| op_d | input | WIDTH | Fourth operand row |
| sum_o | output | WIDTH | Sum vector, bit i of weight 2^i |
| carry_o | output | WIDTH | Carry vector, bit i of weight 2^(i+1) |
| carry_top_o | output | 1 | Lateral carry out of the top lane, weight 2^WIDTH |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the operand ports and the outputs. The bench changes operands just after a rising clock edge. It samples sum_o, carry_o and carry_top_o at the following falling edge, half a period later, once the logic has settled. No result is read across a clock edge. The locality checks hold the operands across two such windows: one pattern, then the same pattern with a single bit flipped. The difference is taken between those two settled samples.

// File: rtl/cmp42_pkg.sv
package cmp42_pkg;
  typedef struct packed {
    logic sum;
    logic carry;
    logic cout;
  } cell_res_t;

  function automatic int unsigned total_width(int unsigned w);
    return w + 2;
  endfunction
endpackage

// File: rtl/cmp42_xpair.sv
module cmp42_xpair (
  input  logic a,
  input  logic b,
  output logic x,
  output logic xn
);
  always_comb begin
    x  = a ^ b;
    xn = ~(a ^ b);
  end
endmodule

// File: rtl/cmp42_mux.sv
module cmp42_mux (
  input  logic sel,
  input  logic d0,
  input  logic d1,
  output logic y
);
  always_comb y = sel ? d1 : d0;
endmodule

// File: rtl/cmp42_cell.sv
module cmp42_cell
  import cmp42_pkg::*;
(
  input  logic      x1,
  input  logic      x2,
  input  logic      x3,
  input  logic      x4,
  input  logic      cin,
  output cell_res_t res
);
  logic p, pn, q, qn;
  logic s4, s4n;
  logic sum_w, carry_w, cout_w;

  // level 1: both polarities of each operand pair
  cmp42_xpair u_pair_lo (.a(x1), .b(x2), .x(p), .xn(pn));
  cmp42_xpair u_pair_hi (.a(x3), .b(x4), .x(q), .xn(qn));

  // lateral carry: majority of x1..x3, never touches cin
  cmp42_mux u_cout (.sel(p), .d0(x1), .d1(x3), .y(cout_w));

  // level 2: four-input parity in both polarities, mux replaces second XOR
  cmp42_mux u_par   (.sel(q),  .d0(p),  .d1(pn), .y(s4));
  cmp42_mux u_par_n (.sel(qn), .d0(p),  .d1(pn), .y(s4n));

  // level 3: fold in the carry from the lane below
  cmp42_mux u_sum   (.sel(cin), .d0(s4), .d1(s4n), .y(sum_w));
  cmp42_mux u_carry (.sel(s4),  .d0(x4), .d1(cin), .y(carry_w));

  always_comb begin
    res.sum   = sum_w;
    res.carry = carry_w;
    res.cout  = cout_w;
  end
endmodule

// File: rtl/cmp42_row.sv
module cmp42_row
  import cmp42_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] op_c,
  input  logic [WIDTH-1:0] op_d,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o,
  output logic             carry_top_o
);
  localparam int unsigned LINKS = WIDTH + 1;

  logic [LINKS-1:0] lat_c;
  cell_res_t        lane_res [WIDTH];

  assign lat_c[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    cmp42_cell u_cell (
      .x1 (op_a[i]),
      .x2 (op_b[i]),
      .x3 (op_c[i]),
      .x4 (op_d[i]),
      .cin(lat_c[i]),
      .res(lane_res[i])
    );
    assign lat_c[i+1]  = lane_res[i].cout;
    assign sum_o[i]    = lane_res[i].sum;
    assign carry_o[i]  = lane_res[i].carry;
  end

  assign carry_top_o = lat_c[WIDTH];
endmodule

// File: rtl/cmp42_row_chk.sv
module cmp42_row_chk
  import cmp42_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] op_c,
  input logic [WIDTH-1:0] op_d,
  input logic [WIDTH-1:0] sum_o,
  input logic [WIDTH-1:0] carry_o,
  input logic             carry_top_o,
  input logic [WIDTH:0]   lat_c
);
  localparam int unsigned TW = total_width(WIDTH);

  logic [TW-1:0] in_total, out_total;

  always_comb begin
    in_total  = TW'(op_a) + TW'(op_b) + TW'(op_c) + TW'(op_d);
    out_total = TW'(sum_o) + (TW'(carry_o) << 1) + (TW'(carry_top_o) << WIDTH);
    assert_total_R1: assert (in_total == out_total);
    assert_top_major_R2: assert (carry_top_o ==
      ($countones({op_a[WIDTH-1], op_b[WIDTH-1], op_c[WIDTH-1]}) >= 2));
    for (int i = 0; i < WIDTH; i++) begin
      assert_lane_cout_R5: assert (lat_c[i+1] ==
        ($countones({op_a[i], op_b[i], op_c[i]}) >= 2));
      assert_lane_sum_R6: assert (sum_o[i] ==
        (op_a[i] ^ op_b[i] ^ op_c[i] ^ op_d[i] ^ lat_c[i]));
      assert_lane_weight_R4: assert (
        $countones({op_a[i], op_b[i], op_c[i], op_d[i], lat_c[i]}) ==
        32'(sum_o[i]) + 2 * (32'(carry_o[i]) + 32'(lat_c[i+1])));
    end
  end
endmodule

bind cmp42_row cmp42_row_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
  .sum_o(sum_o), .carry_o(carry_o), .carry_top_o(carry_top_o),
  .lat_c(lat_c)
);

// File: tb/cmp42_row_test.sv
module cmp42_row_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 7;
  localparam int TW = W + 2;

  // {a, b, c, d, expected total}
  localparam logic [4*W+TW-1:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 10'd0},
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 10'd1020},
    {8'h01, 8'h01, 8'h01, 8'h01, 10'd4},
    {8'h80, 8'h80, 8'h80, 8'h80, 10'd512},
    {8'hAA, 8'h55, 8'hAA, 8'h55, 10'd510},
    {8'h0F, 8'hF0, 8'h33, 8'hCC, 10'd510},
    {8'h12, 8'h34, 8'h56, 8'h78, 10'd276}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b, c, d;
  logic [W-1:0] sum_o, carry_o;
  logic carry_top_o;
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp42_row #(.WIDTH(W)) uut (
    .op_a(a), .op_b(b), .op_c(c), .op_d(d),
    .sum_o(sum_o), .carry_o(carry_o), .carry_top_o(carry_top_o)
  );

  function automatic logic maj3(logic x, logic y, logic z);
    return (32'(x) + 32'(y) + 32'(z)) >= 2;
  endfunction

  function automatic logic [2*W:0] spec_out(logic [W-1:0] pa, logic [W-1:0] pb,
                                            logic [W-1:0] pc, logic [W-1:0] pd);
    logic [W-1:0] s, k;
    logic ci;
    ci = 1'b0;
    for (int i = 0; i < W; i++) begin
      s[i] = pa[i] ^ pb[i] ^ pc[i] ^ pd[i] ^ ci;
      k[i] = maj3(pa[i] ^ pb[i] ^ pc[i], pd[i], ci);
      ci   = maj3(pa[i], pb[i], pc[i]);
    end
    return {ci, k, s};
  endfunction

  task automatic apply(logic [W-1:0] pa, logic [W-1:0] pb,
                       logic [W-1:0] pc, logic [W-1:0] pd);
    @(posedge clk);
    #1;
    a = pa; b = pb; c = pc; d = pd;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] out_total();
    return TW'(sum_o) + (TW'(carry_o) << 1) + (TW'(carry_top_o) << W);
  endfunction

  task automatic check_all(string req);
    logic [2*W:0] e;
    e = spec_out(a, b, c, d);
    check({req, " R1 total"}, out_total(),
          TW'(a) + TW'(b) + TW'(c) + TW'(d));
    check("R6 sum", TW'(sum_o), TW'(e[W-1:0]));
    check("R5 carry", TW'(carry_o), TW'(e[2*W-1:W]));
    check("R2 top", TW'(carry_top_o), TW'(e[2*W]));
  endtask

  initial begin
    a = '0; b = '0; c = '0; d = '0;
    // R7: outputs idle at zero while the bench holds reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 reset sum", TW'(sum_o), '0);
    check("R7 reset carry", TW'(carry_o), '0);
    check("R7 reset top", TW'(carry_top_o), '0);
    rst_n = 1'b1;

    // table walk: R1 totals and exact per-lane outputs
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][4*W+TW-1 -: W], VEC[v][3*W+TW-1 -: W],
            VEC[v][2*W+TW-1 -: W], VEC[v][W+TW-1 -: W]);
      check("R1 table", out_total(), VEC[v][TW-1:0]);
      check_all("table");
    end

    // all ones: exact vectors
    apply('1, '1, '1, '1);
    check("R6 ones sum", TW'(sum_o), TW'(8'hFE));
    check("R5 ones carry", TW'(carry_o), TW'(8'hFF));

    // R3: lowest lane carry-in is zero
    apply(8'h01, 8'h00, 8'h00, 8'h01);
    check("R3 sum", TW'(sum_o), '0);
    check("R3 carry", TW'(carry_o), TW'(1));
    apply(8'h01, 8'h01, 8'h00, 8'h00);
    check("R3 lateral sum", TW'(sum_o), TW'(8'h02));
    check("R3 lateral carry", TW'(carry_o), '0);

    // R2: top carry ignores op_d and lower bits
    apply(8'h80, 8'h80, 8'h00, 8'hFF);
    check("R2 two set", TW'(carry_top_o), TW'(1));
    apply(8'h7F, 8'hFF, 8'h7F, 8'hFF);
    check("R2 one set", TW'(carry_top_o), '0);
    apply(8'h00, 8'h00, 8'h00, 8'h80);
    check("R2 d only", TW'(carry_top_o), '0);

    // random patterns
    for (int n = 0; n < 200; n++) begin
      apply(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
      check_all("random");
    end

    // R4: one-bit flips disturb only lanes j and j+1
    for (int n = 0; n < 64; n++) begin
      logic [W-1:0] s0, k0, s1, k1, msk;
      logic t0;
      int j;
      int opsel;
      j = int'($urandom % W);
      opsel = int'($urandom % 4);
      apply(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
      s0 = sum_o; k0 = carry_o; t0 = carry_top_o;
      @(posedge clk);
      #1;
      case (opsel)
        0: a[j] = ~a[j];
        1: b[j] = ~b[j];
        2: c[j] = ~c[j];
        default: d[j] = ~d[j];
      endcase
      @(negedge clk);
      s1 = sum_o; k1 = carry_o;
      msk = W'(3) << j;
      check("R4 sum locality", TW'((s0 ^ s1) & ~msk), '0);
      check("R4 carry locality", TW'((k0 ^ k1) & ~msk), '0);
      if (j != W-1)
        check("R4 top locality", TW'(carry_top_o), TW'(t0));
      check_all("R4 flip");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule